// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast clock by a programmable integer N = B·P + A. It does so by pulse swallowing. A prescaler divides the clock by either P or P+1. Two counters run on the prescaler's output: a 6-bit swallow count A and an 11-bit main count B. For the first A prescaler cycles of each output period the prescaler divides by P+1. For the remaining B−A prescaler cycles it divides by P. The prescaler base is selectable: P = 32 (dividing by 32/33) or P = 64 (dividing by 64/65). The whole divider, prescaler included, is synchronous logic clocked by the input clock.

A configuration is presented on the inputs and captured by a one-cycle load strobe. It is held pending and takes effect only at the next output period boundary, so a period in progress always completes with the ratio it started with. When the divider is idle (after reset, or after an invalid setting), a pending configuration takes effect on the next clock. A setting with B < A, or with B = 0, stops the divider and raises an error flag until a valid setting is loaded. The output is a one-clock-wide pulse that marks the end of each N-cycle period.

Top module: `pulse_swallow_div`

## Requirements
- R1: While running, rising edges of `div_pulse` are exactly N = B·P + A clock cycles apart. P is 32 when the captured `cfg_wide_mod` is 0 and 64 when it is 1.
- R2: Each `div_pulse` assertion lasts exactly one clock cycle.
- R3: With A = 0 the prescaler never uses the P+1 modulus, so the period is B·P.
- R4: With A = B every prescaler cycle uses P+1, so the period is B·(P+1).
- R5: A captured setting with A > B or with B = 0 makes `cfg_error` go high and keeps `div_pulse` low from then on.
- R6: A setting loaded in the middle of a period does not change that period's length. The new N applies from the next period onward.
- R7: After reset, and until the first load, `div_pulse` and `cfg_error` are both low.
- R8: From the idle state, a valid load clears `cfg_error` on the following clock. `div_pulse` then first rises at the (N+1)-th rising edge after the edge that samples `cfg_load`.
- R9: When several loads occur within one period, the last one is the one applied at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration inputs |
| cfg_wide_mod | input | 1 | Prescaler base: 0 selects 32/33, 1 selects 64/65 |
| cfg_swallow | input | 6 | Swallow count A |
| cfg_main | input | 11 | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the end of each N-cycle period |
| cfg_error | output | 1 | High while an invalid setting (A > B or B = 0) is in force |

## Verification
The hardest situation to reach from the ports is a reload that lands while a period is already running. This matters most when several loads fall inside one period, because only the final one may reach the counters, and only at the boundary. The stimulus first locks onto a pulse. It then issues loads at known cycle offsets inside the running period and counts the cycles from that pulse to the next. The in-flight period must keep its old length, and the following period must show only the last setting loaded. The small configurations are swept almost exhaustively for both prescaler bases, so that A = 0, A = B and A = B−1 each fall at both moduli.

// File: rtl/pswd_pkg.sv
`timescale 1ns/1ps
package pswd_pkg;

  // Prescaler base selection captured with each configuration.
  typedef enum logic {
    MOD_NARROW = 1'b0,  // base P = 2**P_LOG_LO
    MOD_WIDE   = 1'b1   // base P = 2**P_LOG_HI
  } pswd_mod_e;

endpackage

// File: rtl/pswd_cfg.sv
`timescale 1ns/1ps
module pswd_cfg
  import pswd_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           wide_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           period_end,
  output logic           apply,
  output logic [A_W-1:0] nxt_a,
  output logic [B_W-1:0] nxt_b,
  output pswd_mod_e      act_mod,
  output logic           run,
  output logic           err
);

  localparam int EXT_W = B_W - A_W;

  // pending (shadow) configuration
  logic [A_W-1:0] pend_a_q, pend_a_d;
  logic [B_W-1:0] pend_b_q, pend_b_d;
  pswd_mod_e      pend_mod_q, pend_mod_d;
  logic           pend_vld_q, pend_vld_d;
  logic           pend_en;

  // active configuration
  logic [A_W-1:0] act_a_q, act_a_d;
  logic [B_W-1:0] act_b_q, act_b_d;
  pswd_mod_e      act_mod_q, act_mod_d;
  logic           act_en;

  logic           run_q, run_d;
  logic           err_q, err_d;
  logic           pend_ok;

  // validity of the pending setting: B nonzero and B >= A
  always_comb begin
    pend_ok = (pend_b_q != '0) && (pend_b_q >= {{EXT_W{1'b0}}, pend_a_q});
  end

  // a pending setting is applied at a period boundary, or at once when idle
  always_comb begin
    apply = pend_vld_q && (!run_q || period_end);
  end

  // next-state logic
  always_comb begin
    pend_en    = load || apply;
    pend_a_d   = pend_a_q;
    pend_b_d   = pend_b_q;
    pend_mod_d = pend_mod_q;
    pend_vld_d = pend_vld_q;
    if (load) begin
      pend_a_d   = a_in;
      pend_b_d   = b_in;
      pend_mod_d = pswd_mod_e'(wide_in);
      pend_vld_d = 1'b1;
    end else if (apply) begin
      pend_vld_d = 1'b0;
    end

    act_en    = apply;
    act_a_d   = pend_a_q;
    act_b_d   = pend_b_q;
    act_mod_d = pend_mod_q;
    run_d     = pend_ok;
    err_d     = !pend_ok;
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a_q   <= '0;
      pend_b_q   <= '0;
      pend_mod_q <= MOD_NARROW;
      pend_vld_q <= 1'b0;
    end else if (pend_en) begin
      pend_a_q   <= pend_a_d;
      pend_b_q   <= pend_b_d;
      pend_mod_q <= pend_mod_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q   <= '0;
      act_b_q   <= '0;
      act_mod_q <= MOD_NARROW;
      run_q     <= 1'b0;
      err_q     <= 1'b0;
    end else if (act_en) begin
      act_a_q   <= act_a_d;
      act_b_q   <= act_b_d;
      act_mod_q <= act_mod_d;
      run_q     <= run_d;
      err_q     <= err_d;
    end
  end

  // counter reload values: the setting about to become active
  always_comb begin
    nxt_a   = apply ? pend_a_q : act_a_q;
    nxt_b   = apply ? pend_b_q : act_b_q;
    act_mod = act_mod_q;
    run     = run_q;
    err     = err_q;
  end

  // R6: the active setting changes only when a setting is applied
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable({act_a_q, act_b_q, act_mod_q}));

  // R5: running and error are never both set
  p_run_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && err_q));

endmodule

// File: rtl/pswd_prescaler.sv
`timescale 1ns/1ps
module pswd_prescaler
  import pswd_pkg::*;
#(
  parameter int P_LOG_LO = 5,
  parameter int P_LOG_HI = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  pswd_mod_e mod,
  input  logic      wide,   // divide by P+1 in this prescaler cycle
  output logic      tick
);

  localparam int PC_W = P_LOG_HI + 1;
  localparam int P_LO = 1 << P_LOG_LO;
  localparam int P_HI = 1 << P_LOG_HI;

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] last;
  logic            pc_en;

  always_comb begin
    base = (mod == MOD_WIDE) ? PC_W'(P_HI) : PC_W'(P_LO);
    last = wide ? base : (base - PC_W'(1));
    tick = run && (pc_q == last);
  end

  always_comb begin
    pc_en = run || (pc_q != '0);
    if (!run || tick) pc_d = '0;
    else              pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // R1: the phase count never passes the largest modulus P_HI+1
  p_pc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(P_HI));

endmodule

// File: rtl/pswd_swallow.sv
`timescale 1ns/1ps
module pswd_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           tick,
  input  logic           reload,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           wide,
  output logic           period_end
);

  localparam int EXT_W = B_W - A_W;

  logic [A_W-1:0] a_left_q, a_left_d;
  logic [B_W-1:0] b_left_q, b_left_d;
  logic           cnt_en;

  always_comb begin
    wide       = (a_left_q != '0);
    period_end = tick && (b_left_q == B_W'(1));
  end

  always_comb begin
    cnt_en   = reload || tick;
    a_left_d = a_left_q;
    b_left_d = b_left_q;
    if (reload) begin
      a_left_d = nxt_a;
      b_left_d = nxt_b;
    end else if (tick) begin
      b_left_d = b_left_q - B_W'(1);
      if (wide) a_left_d = a_left_q - A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_left_q <= '0;
      b_left_q <= '0;
    end else if (cnt_en) begin
      a_left_q <= a_left_d;
      b_left_q <= b_left_d;
    end
  end

  // R1: swallow cycles left never exceed main cycles left while running
  p_swallow_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({{EXT_W{1'b0}}, a_left_q} <= b_left_q));

  // R1: a running divider never holds an empty main count
  p_main_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (b_left_q != '0));

endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
  import pswd_pkg::*;
#(
  parameter int A_W      = 6,
  parameter int B_W      = 11,
  parameter int P_LOG_LO = 5,
  parameter int P_LOG_HI = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_wide_mod,
  input  logic [A_W-1:0] cfg_swallow,
  input  logic [B_W-1:0] cfg_main,
  output logic           div_pulse,
  output logic           cfg_error
);

  logic [1:0]     rst_sync_q;
  logic           rst_n_i;
  logic           apply;
  logic [A_W-1:0] nxt_a;
  logic [B_W-1:0] nxt_b;
  pswd_mod_e      act_mod;
  logic           run;
  logic           err;
  logic           tick;
  logic           wide;
  logic           period_end;
  logic           reload;
  logic           pulse_q, pulse_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pswd_cfg #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (cfg_load),
    .wide_in    (cfg_wide_mod),
    .a_in       (cfg_swallow),
    .b_in       (cfg_main),
    .period_end (period_end),
    .apply      (apply),
    .nxt_a      (nxt_a),
    .nxt_b      (nxt_b),
    .act_mod    (act_mod),
    .run        (run),
    .err        (err)
  );

  pswd_prescaler #(.P_LOG_LO(P_LOG_LO), .P_LOG_HI(P_LOG_HI)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (run),
    .mod   (act_mod),
    .wide  (wide),
    .tick  (tick)
  );

  always_comb reload = apply || period_end;

  pswd_swallow #(.A_W(A_W), .B_W(B_W)) u_swl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .run        (run),
    .tick       (tick),
    .reload     (reload),
    .nxt_a      (nxt_a),
    .nxt_b      (nxt_b),
    .wide       (wide),
    .period_end (period_end)
  );

  always_comb pulse_d = period_end;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pulse_q <= 1'b0;
    else          pulse_q <= pulse_d;
  end

  assign div_pulse = pulse_q;
  assign cfg_error = err;

  // R2: the output pulse is one clock wide
  p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    div_pulse |=> !div_pulse);

  // R5: no pulse follows a cycle in which the error flag is set
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_error |=> !div_pulse);

endmodule

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic        cfg_wide_mod;
  logic [5:0]  cfg_swallow;
  logic [10:0] cfg_main;
  logic        div_pulse;
  logic        cfg_error;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pulse_swallow_div u_pulse_swallow_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_wide_mod (cfg_wide_mod),
    .cfg_swallow  (cfg_swallow),
    .cfg_main     (cfg_main),
    .div_pulse    (div_pulse),
    .cfg_error    (cfg_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input bit w, input int a, input int b);
    return b * (w ? 64 : 32) + a;
  endfunction

  task automatic do_load(input bit w, input int a, input int b);
    @(negedge clk);
    cfg_wide_mod = w;
    cfg_swallow  = 6'(a);
    cfg_main     = 11'(b);
    cfg_load     = 1'b1;
    @(negedge clk);
    cfg_load     = 1'b0;
  endtask

  task automatic wait_pulse(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (div_pulse) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  // called at a negedge where div_pulse is high; counts cycles to the next pulse
  task automatic count_period(output int n);
    n = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) check(!div_pulse, "R2 pulse width", int'(div_pulse), 0);
      if (div_pulse) break;
    end
  endtask

  task automatic measure(input bit w, input int a, input int b, input string req);
    bit seen;
    int n;
    do_load(w, a, b);
    wait_pulse(seen);
    check(seen, req, int'(seen), 1);
    count_period(n);
    check(n == exp_n(w, a, b), req, n, exp_n(w, a, b));
  endtask

  initial begin
    #(8ns * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    int n;
    int k;
    int hits;
    rst_n        = 1'b0;
    cfg_load     = 1'b0;
    cfg_wide_mod = 1'b0;
    cfg_swallow  = '0;
    cfg_main     = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R7: quiet after reset until a load
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (div_pulse || cfg_error) hits++;
    end
    check(hits == 0, "R7 idle after reset", hits, 0);

    // R8: first pulse latency from idle, A=2 B=3 P=32 -> N=98
    @(negedge clk);
    cfg_wide_mod = 1'b0; cfg_swallow = 6'd2; cfg_main = 11'd3; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    k = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      k++;
      if (div_pulse) break;
    end
    check(k == 99, "R8 first pulse latency", k, 99);

    // R1 / R3 / R4: near-exhaustive sweep of small settings at both bases
    for (int w = 0; w < 2; w++) begin
      for (int b = 1; b <= 5; b++) begin
        for (int a = 0; a <= b; a++) begin
          if (a == 0)      measure(w[0], a, b, "R3 A=0 period");
          else if (a == b) measure(w[0], a, b, "R4 A=B period");
          else             measure(w[0], a, b, "R1 period");
        end
      end
    end
    measure(1'b1, 63, 63, "R4 A=B=63 period");
    measure(1'b0, 0, 100, "R3 large B period");
    measure(1'b1, 17, 40, "R1 mixed period");

    // R6: mid-period load leaves the running period intact
    measure(1'b0, 1, 3, "R1 period");            // N=97 running
    n = 0;
    repeat (10) begin @(negedge clk); n++; end
    @(negedge clk); n++;
    cfg_wide_mod = 1'b0; cfg_swallow = 6'd0; cfg_main = 11'd2; cfg_load = 1'b1;
    @(negedge clk); n++;
    cfg_load = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (div_pulse) break;
      @(negedge clk); n++;
    end
    check(n == 97, "R6 in-flight period kept", n, 97);
    count_period(n);
    check(n == 64, "R6 new period applied", n, 64);

    // R9: two loads in one period, the last one applies
    repeat (5) @(negedge clk);
    do_load(1'b0, 1, 1);
    repeat (3) @(negedge clk);
    do_load(1'b1, 2, 3);
    wait_pulse(seen);
    count_period(n);
    check(n == 194, "R9 last load wins", n, 194);

    // R5: invalid A > B while running
    do_load(1'b0, 5, 3);
    wait_pulse(seen);
    @(negedge clk);
    check(cfg_error, "R5 error on A>B", int'(cfg_error), 1);
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    check(hits == 0, "R5 no pulses on A>B", hits, 0);

    // R5: B = 0 from idle keeps error, no pulses
    do_load(1'b1, 0, 0);
    @(negedge clk);
    check(cfg_error, "R5 error on B=0", int'(cfg_error), 1);
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
    check(hits == 0, "R5 no pulses on B=0", hits, 0);

    // R8: valid load clears the error and pulses resume
    do_load(1'b1, 0, 1);
    @(negedge clk);
    check(!cfg_error, "R8 error cleared", int'(cfg_error), 0);
    wait_pulse(seen);
    check(seen, "R8 pulses resume", int'(seen), 1);
    count_period(n);
    check(n == 64, "R8 resumed period", n, 64);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule